// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 31-bit virtual address into a 27-bit physical address. The page size is 4 KB, so the low 12 bits are the page offset. The upper 19 bits form the virtual page number, and that number indexes an on-chip page table directly, with no search. Each table entry holds:

- a present flag;
- a 15-bit physical page number;
- a dirty flag;
- two permission bits.

On a successful translation the offset passes through unchanged, and only the page number is replaced by the one from the entry.

Software-side logic loads entries through an entry-write port. A requester presents one access per cycle on the request port, marked as a read or a write. One cycle later a registered response returns one of three results:

- the physical address;
- a page-fault flag, for a missing page;
- a protection-fault flag, for an access the entry's permission bits forbid.

A permitted write marks its page dirty. The response reports the page's dirty state, so software can see which pages need writing back.

The table depth is a parameter, `ENTRIES`, which defaults to 1024. A virtual page number at or above `ENTRIES` is treated as not present.

Top module: `pt_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every table entry is not present, so any lookup made before an entry is loaded returns a page fault.
- R2: A request accepted in cycle N produces `rsp_valid`=1 in cycle N+1. A successful response has `rsp_paddr` = {entry physical page number, `req_vaddr[11:0]`}. For example, with entry 5 mapped to page 1, address 0x5F20 yields 0x1F20.
- R3: A lookup gets a page fault when its entry is not present or its virtual page number (`req_vaddr[30:12]`) is `ENTRIES` or more. The response then has `rsp_page_fault`=1, `rsp_prot_fault`=0, `rsp_paddr`=0 and `rsp_dirty`=0. For example, address 0x73E0 faults when entry 7 is not present. A page fault takes precedence over a protection fault.
- R4: A write (`req_write`=1) to a present page whose write-permit bit (`pte_prot[1]`) is 0 gives `rsp_prot_fault`=1 with `rsp_paddr`=0. It leaves the entry's dirty flag unchanged.
- R5: A read (`req_write`=0) to a present page whose read-permit bit (`pte_prot[0]`) is 0 gives `rsp_prot_fault`=1 with `rsp_paddr`=0.
- R6: A permitted write sets the entry's dirty flag. `rsp_dirty` reports the dirty flag as it stands after the access: 1 for a permitted write, and the stored flag for a permitted read. It is 0 on any fault.
- R7: An entry write (`pte_we`=1) replaces the present flag, page number and permission bits of entry `pte_idx`, and clears its dirty flag. A lookup of the same entry in the same cycle sees the old contents. When a permitted write to that entry falls in the same cycle, the entry write wins and the dirty flag ends up cleared.
- R8: In a cycle after no request, `rsp_valid`, both fault flags, `rsp_dirty` and `rsp_paddr` are all 0.
- R9: An entry write with `pte_idx` of `ENTRIES` or more is ignored and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present this cycle |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | 31 | Virtual address to translate |
| pte_we | input | 1 | Entry-write strobe |
| pte_idx | input | 19 | Virtual page number of the entry to write |
| pte_ppn | input | 15 | Physical page number to store |
| pte_valid | input | 1 | Present flag to store |
| pte_prot | input | 2 | Permission bits to store: bit 0 read permit, bit 1 write permit |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | 27 | Translated physical address, 0 on a fault |
| rsp_page_fault | output | 1 | Page is not present or out of range |
| rsp_prot_fault | output | 1 | Access denied by the permission bits |
| rsp_dirty | output | 1 | Page dirty state after this access |

## Verification
The assertions check the following on every cycle:

- the response arrives exactly one cycle after each request;
- an idle cycle leaves the response quiet;
- the two fault flags never rise together;
- a dirty report comes only with a successful translation;
- a translation keeps the offset;
- out-of-range page numbers always fault.

Only the bench's scenarios can show behaviour that depends on stored state. That covers the page numbers returned for loaded entries, the effect of the permission bits, and the dirty flag persisting across accesses. It also covers the read-old-contents rule for a colliding entry write, and out-of-range entry writes leaving the table untouched.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int VA_W    = 31;
    localparam int PA_W    = 27;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int PROT_W  = 2;
    localparam int PROT_RD = 0;
    localparam int PROT_WR = 1;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [PROT_W-1:0] prot;
        logic [PPN_W-1:0]  ppn;
    } pte_t;

    typedef struct packed {
        logic             valid;
        logic             page_fault;
        logic             prot_fault;
        logic             dirty;
        logic [PA_W-1:0]  paddr;
    } rsp_t;

    function automatic logic access_allowed(input logic [PROT_W-1:0] prot,
                                            input logic is_write);
        return is_write ? prot[PROT_WR] : prot[PROT_RD];
    endfunction
endpackage

// File: rtl/pt_table.sv
module pt_table
    import pt_pkg::*;
#(
    parameter int ENTRIES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   rd_vpn,
    output pte_t               rd_pte,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_valid,
    input  logic [PROT_W-1:0]  wr_prot,
    input  logic               dset_en,
    input  logic [VPN_W-1:0]   dset_vpn
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int BODY_W = PROT_W + PPN_W;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [BODY_W-1:0]  body_q [ENTRIES];

    logic             rd_in, wr_in, ds_in;
    logic [IDX_W-1:0] rd_sel, wr_sel, ds_sel;

    assign rd_in  = rd_vpn   < VPN_W'(ENTRIES);
    assign wr_in  = wr_vpn   < VPN_W'(ENTRIES);
    assign ds_in  = dset_vpn < VPN_W'(ENTRIES);
    assign rd_sel = rd_vpn[IDX_W-1:0];
    assign wr_sel = wr_vpn[IDX_W-1:0];
    assign ds_sel = dset_vpn[IDX_W-1:0];

    // Present and dirty flags: reset, updated by entry writes and dirty marks
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_en && wr_in && wr_sel == IDX_W'(e)) begin
                    valid_q[e] <= wr_valid;
                    dirty_q[e] <= 1'b0;
                end else if (dset_en && ds_in && ds_sel == IDX_W'(e)) begin
                    dirty_q[e] <= 1'b1;
                end
            end
        end
    end

    // Page number and permissions: plain storage, no reset
    always_ff @(posedge clk) begin
        if (wr_en && wr_in) begin
            body_q[wr_sel] <= {wr_prot, wr_ppn};
        end
    end

    // Read returns contents from before this cycle's writes
    always_comb begin
        rd_pte = '0;
        if (rd_in) begin
            rd_pte.valid = valid_q[rd_sel];
            rd_pte.dirty = dirty_q[rd_sel];
            {rd_pte.prot, rd_pte.ppn} = body_q[rd_sel];
        end
    end
endmodule

// File: rtl/pt_check.sv
module pt_check
    import pt_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_off,
    input  pte_t             pte,
    output rsp_t             rsp_next,
    output logic             mark_dirty
);
    logic missing, denied, granted;

    assign missing = !pte.valid;
    assign denied  = !missing && !access_allowed(pte.prot, req_write);
    assign granted = req_valid && !missing && !denied;

    always_comb begin
        rsp_next            = '0;
        rsp_next.valid      = req_valid;
        rsp_next.page_fault = req_valid && missing;
        rsp_next.prot_fault = req_valid && denied;
        rsp_next.dirty      = granted && (pte.dirty || req_write);
        if (granted) begin
            rsp_next.paddr = {pte.ppn, req_off};
        end
    end

    assign mark_dirty = granted && req_write;
endmodule

// File: rtl/pt_resp_reg.sv
module pt_resp_reg
    import pt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rsp_t d,
    output rsp_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pt_translator.sv
module pt_translator
    import pt_pkg::*;
#(
    parameter int ENTRIES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              pte_we,
    input  logic [VPN_W-1:0]  pte_idx,
    input  logic [PPN_W-1:0]  pte_ppn,
    input  logic              pte_valid,
    input  logic [PROT_W-1:0] pte_prot,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault,
    output logic              rsp_dirty
);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    pte_t             looked_up;
    rsp_t             rsp_d, rsp_q;
    logic             mark_dirty;

    assign vpn = req_vaddr[VA_W-1:OFF_W];
    assign off = req_vaddr[OFF_W-1:0];

    pt_table #(.ENTRIES(ENTRIES)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_vpn   (vpn),
        .rd_pte   (looked_up),
        .wr_en    (pte_we),
        .wr_vpn   (pte_idx),
        .wr_ppn   (pte_ppn),
        .wr_valid (pte_valid),
        .wr_prot  (pte_prot),
        .dset_en  (mark_dirty),
        .dset_vpn (vpn)
    );

    pt_check check_i (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_off    (off),
        .pte        (looked_up),
        .rsp_next   (rsp_d),
        .mark_dirty (mark_dirty)
    );

    pt_resp_reg resp_i (
        .clk (clk),
        .rst (rst),
        .d   (rsp_d),
        .q   (rsp_q)
    );

    assign rsp_valid      = rsp_q.valid;
    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_page_fault = rsp_q.page_fault;
    assign rsp_prot_fault = rsp_q.prot_fault;
    assign rsp_dirty      = rsp_q.dirty;
endmodule

// File: rtl/pt_translator_chk.sv
module pt_translator_chk
    import pt_pkg::*;
#(
    parameter int ENTRIES = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              pte_we,
    input logic [VPN_W-1:0]  pte_idx,
    input logic [PPN_W-1:0]  pte_ppn,
    input logic              pte_valid,
    input logic [PROT_W-1:0] pte_prot,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_page_fault,
    input logic              rsp_prot_fault,
    input logic              rsp_dirty
);
    // R2: a response follows each request one cycle later
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R8: no response without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: an idle response is all zero
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_page_fault && !rsp_prot_fault && !rsp_dirty && rsp_paddr == '0));

    // R3: the two fault kinds are exclusive
    a_r3_fault_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_page_fault && rsp_prot_fault));

    // R3: a faulting response carries no address
    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_paddr == '0 && !rsp_dirty));

    // R3: out-of-range page numbers fault
    a_r3_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[VA_W-1:OFF_W] >= VPN_W'(ENTRIES)) |=> rsp_page_fault);

    // R2: the offset passes through on a successful translation
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[VA_W-1:OFF_W] < VPN_W'(ENTRIES)) |=>
        (rsp_page_fault || rsp_prot_fault ||
         rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R6: a permitted write always reports dirty
    a_r6_write_dirty: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_dirty || rsp_page_fault || rsp_prot_fault));
endmodule

bind pt_translator pt_translator_chk #(.ENTRIES(ENTRIES)) chk_i (.*);

// File: tb/pt_translator_tb_top.sv
module pt_translator_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [30:0] va;
        logic        pf;
        logic        prf;
        logic [26:0] pa;
        logic        dirty;
    } vec_t;

    // Entries loaded first: 5->ppn 1 rw, 2->ppn 7FFF read-only,
    // 3->ppn 0A5 write-only, 9->ppn 123 rw; 7 never present
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 31'h0000_5F20, 1'b0, 1'b0, 27'h000_1F20, 1'b0}, // R2 example
        '{1'b0, 31'h0000_73E0, 1'b1, 1'b0, 27'h0,        1'b0}, // R3 example
        '{1'b0, 31'h0000_2ABC, 1'b0, 1'b0, 27'h7FF_FABC, 1'b0}, // R2 top ppn
        '{1'b1, 31'h0000_2ABC, 1'b0, 1'b1, 27'h0,        1'b0}, // R4 write denied
        '{1'b0, 31'h0000_2ABC, 1'b0, 1'b0, 27'h7FF_FABC, 1'b0}, // R4 dirty untouched
        '{1'b0, 31'h0000_3001, 1'b0, 1'b1, 27'h0,        1'b0}, // R5 read denied
        '{1'b1, 31'h0000_3FFF, 1'b0, 1'b0, 27'h00A_5FFF, 1'b1}, // R6 write ok
        '{1'b1, 31'h0000_5000, 1'b0, 1'b0, 27'h000_1000, 1'b1}, // R6
        '{1'b0, 31'h0000_5FFF, 1'b0, 1'b0, 27'h000_1FFF, 1'b1}, // R6 dirty kept
        '{1'b0, 31'h0040_0000, 1'b1, 1'b0, 27'h0,        1'b0}, // R3 vpn 1024
        '{1'b0, 31'h7FFF_FFFF, 1'b1, 1'b0, 27'h0,        1'b0}, // R3 top address
        '{1'b0, 31'h0000_9000, 1'b0, 1'b0, 27'h012_3000, 1'b0}  // R2
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [30:0] req_vaddr;
    logic        pte_we, pte_valid;
    logic [18:0] pte_idx;
    logic [14:0] pte_ppn;
    logic [1:0]  pte_prot;
    logic        rsp_valid, rsp_page_fault, rsp_prot_fault, rsp_dirty;
    logic [26:0] rsp_paddr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_translator dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .pte_we(pte_we), .pte_idx(pte_idx), .pte_ppn(pte_ppn),
        .pte_valid(pte_valid), .pte_prot(pte_prot),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .rsp_dirty(rsp_dirty)
    );

    task automatic check_rsp(input string tag, input logic v, input logic pf,
                             input logic prf, input logic [26:0] pa, input logic d);
        checks++;
        if (rsp_valid !== v || rsp_page_fault !== pf || rsp_prot_fault !== prf ||
            rsp_paddr !== pa || rsp_dirty !== d) begin
            failures++;
            $display("FAIL %s: got v=%b pf=%b prf=%b pa=%h d=%b, expected v=%b pf=%b prf=%b pa=%h d=%b",
                     tag, rsp_valid, rsp_page_fault, rsp_prot_fault, rsp_paddr, rsp_dirty,
                     v, pf, prf, pa, d);
        end
    endtask

    task automatic load(input logic [18:0] idx, input logic [14:0] ppn,
                        input logic v, input logic [1:0] prot);
        @(negedge clk);
        pte_we = 1'b1; pte_idx = idx; pte_ppn = ppn; pte_valid = v; pte_prot = prot;
        @(negedge clk);
        pte_we = 1'b0;
    endtask

    // Drives a request for one cycle; returns at the negedge where the response is visible
    task automatic request(input logic wr, input logic [30:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
        pte_we = 1'b0; pte_idx = '0; pte_ppn = '0; pte_valid = 1'b0; pte_prot = '0;
        repeat (3) @(negedge clk);
        check_rsp("R1 reset response", 1'b0, 1'b0, 1'b0, 27'h0, 1'b0);
        rst = 1'b0;

        request(1'b0, 31'h0000_5F20);
        check_rsp("R1 lookup before load", 1'b1, 1'b1, 1'b0, 27'h0, 1'b0);

        load(19'd5, 15'h0001, 1'b1, 2'b11);
        load(19'd2, 15'h7FFF, 1'b1, 2'b01);
        load(19'd3, 15'h00A5, 1'b1, 2'b10);
        load(19'd9, 15'h0123, 1'b1, 2'b11);

        for (int i = 0; i < NV; i++) begin
            request(VECS[i].wr, VECS[i].va);
            check_rsp($sformatf("R2/R3/R4/R5/R6 vector %0d", i), 1'b1,
                      VECS[i].pf, VECS[i].prf, VECS[i].pa, VECS[i].dirty);
        end

        // R8: idle cycle after a request
        @(negedge clk);
        check_rsp("R8 idle", 1'b0, 1'b0, 1'b0, 27'h0, 1'b0);

        // R7: same-cycle entry write and write lookup of entry 9
        @(negedge clk);
        pte_we = 1'b1; pte_idx = 19'd9; pte_ppn = 15'h0456; pte_valid = 1'b1; pte_prot = 2'b11;
        req_valid = 1'b1; req_write = 1'b1; req_vaddr = 31'h0000_9010;
        @(negedge clk);
        pte_we = 1'b0; req_valid = 1'b0;
        check_rsp("R7 old contents on collision", 1'b1, 1'b0, 1'b0, 27'h012_3010, 1'b1);
        request(1'b0, 31'h0000_9010);
        check_rsp("R7 new contents, dirty cleared", 1'b1, 1'b0, 1'b0, 27'h045_6010, 1'b0);

        // R7: entry write removes a page
        load(19'd5, 15'h0001, 1'b0, 2'b11);
        request(1'b0, 31'h0000_5F20);
        check_rsp("R7 invalidated page faults", 1'b1, 1'b1, 1'b0, 27'h0, 1'b0);

        // R9: out-of-range entry write is ignored, no aliasing onto entry 0
        load(19'd1024, 15'h0007, 1'b1, 2'b11);
        request(1'b0, 31'h0040_0000);
        check_rsp("R9 out-of-range index still faults", 1'b1, 1'b1, 1'b0, 27'h0, 1'b0);
        request(1'b0, 31'h0000_0000);
        check_rsp("R9 entry 0 untouched", 1'b1, 1'b1, 1'b0, 27'h0, 1'b0);

        // R1: reset clears loaded entries
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        request(1'b0, 31'h0000_3FFF);
        check_rsp("R1 reset clears entries", 1'b1, 1'b1, 1'b0, 27'h0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule